// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Almost-Full Level

This block moves data words from one clock domain to another through a small register array. The writer presents a word with `wr_valid` and sees `full` and `almost_full` in its own clock domain. The reader takes the word at the head from `rd_data` with `rd_ready` and sees `empty` in its own clock domain. Each side has its own counter for its pointer. Each pointer is kept in binary and, in parallel, in reflected Gray code. The Gray register is loaded from the Gray conversion of the counter's next value, so both registers step together and the Gray value never shows a decoding glitch.

A Gray pointer that crosses into the other domain goes through a two-flop synchronizer. Full and empty are found by comparing pointers for identity. Each pointer carries one extra wrap bit that tells a full array from an empty one.

The almost-full flag compares the write-side fill level with one of eight preset levels. A select value loaded in the write domain picks the level. Level k is `(k+1)*DEPTH/8` entries.

The block has no state machine. Its sequencing is the two pointer counters and the flag registers they drive.

Top module: `afifo_sel_af`

## Requirements
- R1: After both resets, `empty` is 1, `full` is 0 and `almost_full` is 0. The level select resets to 7, which is a level of DEPTH.
- R2: Words come out on `rd_data` in the order they were accepted. `rd_data` shows the head word whenever `empty` is 0.
- R3: With the reader idle, `full` rises on the write-clock edge that accepts the DEPTH-th stored word. A write while `full` is 1 is dropped and stores nothing.
- R4: A read request while `empty` is 1 is ignored: it does not move the read pointer and does not discard data.
- R5: `empty` falls within a few read-clock cycles after a word has been written. `empty` rises on the read edge that removes the last stored word.
- R6: `almost_full` is 1 exactly when the write-side fill level is at least `(s+1)*DEPTH/8`. Here s is the 3-bit select value, loaded from `af_sel` on a write-clock edge where `af_sel_load` is 1.
- R7: Each Gray pointer changes in at most one bit per clock of its own domain.
- R8: The write-side fill level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_valid | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry, as seen by the write side |
| almost_full | output | 1 | Fill level has reached the selected preset |
| af_sel | input | 3 | Preset level index, 0 to 7 |
| af_sel_load | input | 1 | Loads `af_sel` into the select register |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_ready | input | 1 | Read request, takes the head word |
| rd_data | output | DATA_W | Head word |
| empty | output | 1 | No stored word, as seen by the read side |

## Verification
A wrong binary or Gray pointer shows up at the ports in several ways. The flags are wrong on the next edge of the owning domain: `full` misses the DEPTH-th write, or `empty` rises one word early. A pointer that moved on a dropped write or read shows up later, as a missing or repeated word on `rd_data` when the array is drained. A wrong fill-level subtraction or a wrong preset shows up as an `almost_full` mismatch. That mismatch appears on the first write that crosses the selected level. The bench sweeps all eight selects.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    localparam int NUM_LEVELS = 8;

    typedef logic [2:0] af_sel_t;

    // Preset fill level for select index k.
    function automatic int level_of(input int k, input int depth);
        return ((k + 1) * depth) / NUM_LEVELS;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
    parameter int DATA_W = 8,
    parameter int AW     = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/afifo_wside.sv
module afifo_wside
    import afifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_valid,
    input  logic [AW:0]   rq_gray,
    input  logic          sel_load,
    input  af_sel_t       sel_in,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          almost_full
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin, wbin_n, wgray_n, rq_bin, fill;
    logic          full_n;
    af_sel_t       sel_q;
    logic [PW-1:0] lvl [NUM_LEVELS];

    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_lvl
        assign lvl[k] = PW'(level_of(k, DEPTH));
    end

    assign push    = wr_valid & ~full;
    assign wbin_n  = wbin + PW'(push);
    assign wgray_n = (wbin_n >> 1) ^ wbin_n;
    assign waddr   = wbin[AW-1:0];

    always_comb begin
        for (int i = 0; i < PW; i++) rq_bin[i] = ^(rq_gray >> i);
    end

    assign fill        = wbin - rq_bin;
    assign almost_full = (fill >= lvl[sel_q]);
    assign full_n      = (wgray_n == {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]});

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
            sel_q <= af_sel_t'(NUM_LEVELS - 1);
        end else begin
            wbin  <= wbin_n;
            wgray <= wgray_n;
            full  <= full_n;
            if (sel_load) sel_q <= sel_in;
        end
    end

    a_r3_drop_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
        (full && wr_valid) |=> $stable(wbin));
    a_r7_wgray_one_bit: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
    a_r8_fill_bounded: assert property (@(posedge wclk) disable iff (!wrst_n)
        fill <= PW'(DEPTH));
endmodule

// File: rtl/afifo_rside.sv
module afifo_rside #(
    parameter int AW = 4
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_ready,
    input  logic [AW:0]   wq_gray,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin, rbin_n, rgray_n;
    logic          pop;

    assign pop     = rd_ready & ~empty;
    assign rbin_n  = rbin + PW'(pop);
    assign rgray_n = (rbin_n >> 1) ^ rbin_n;
    assign raddr   = rbin[AW-1:0];

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
            empty <= 1'b1;
        end else begin
            rbin  <= rbin_n;
            rgray <= rgray_n;
            empty <= (rgray_n == wq_gray);
        end
    end

    a_r4_hold_when_empty: assert property (@(posedge rclk) disable iff (!rrst_n)
        (empty && rd_ready) |=> $stable(rbin));
    a_r7_rgray_one_bit: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/afifo_sel_af.sv
module afifo_sel_af
    import afifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AW     = 4
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full,
    input  logic [2:0]        af_sel,
    input  logic              af_sel_load,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    logic          push;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wq_gray, rq_gray;

    afifo_wside #(.AW(AW)) u_wside (
        .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .rq_gray(rq_gray),
        .sel_load(af_sel_load), .sel_in(af_sel_t'(af_sel)), .push(push),
        .waddr(waddr), .wgray(wgray), .full(full), .almost_full(almost_full)
    );

    afifo_rside #(.AW(AW)) u_rside (
        .rclk(rclk), .rrst_n(rrst_n), .rd_ready(rd_ready), .wq_gray(wq_gray),
        .raddr(raddr), .rgray(rgray), .empty(empty)
    );

    afifo_sync #(.W(AW + 1)) u_sync_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wq_gray)
    );

    afifo_sync #(.W(AW + 1)) u_sync_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rq_gray)
    );

    afifo_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
        .wclk(wclk), .we(push), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: tb/afifo_sel_af_tb.sv
module afifo_sel_af_tb_top;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DATA_W = 8;
    localparam int AW     = 4;
    localparam int DEPTH  = 1 << AW;

    logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
    logic wr_valid = 0, af_sel_load = 0, rd_ready = 0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [2:0] af_sel = '0;
    logic full, almost_full, empty;
    logic [DATA_W-1:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [DATA_W-1:0] model_q [$];

    always #(WCLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    afifo_sel_af #(.DATA_W(DATA_W), .AW(AW)) dut_i (
        .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .full(full), .almost_full(almost_full), .af_sel(af_sel),
        .af_sel_load(af_sel_load), .rclk(rclk), .rrst_n(rrst_n),
        .rd_ready(rd_ready), .rd_data(rd_data), .empty(empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge wclk);
        repeat (6) @(posedge rclk);
    endtask

    task automatic wr(input logic [DATA_W-1:0] d);
        bit acc;
        @(negedge wclk);
        wr_valid = 1; wr_data = d; acc = !full;
        @(posedge wclk);
        if (acc) model_q.push_back(d);
        #1 wr_valid = 0;
    endtask

    task automatic rd_check(input string req);
        @(negedge rclk);
        check(empty == 0, req, empty, 0);
        if (!empty) begin
            check(rd_data == model_q[0], "R2 order", rd_data, model_q[0]);
            rd_ready = 1;
            @(posedge rclk);
            #1 rd_ready = 0;
            void'(model_q.pop_front());
        end
    endtask

    task automatic load_sel(input int s);
        @(negedge wclk);
        af_sel = 3'(s); af_sel_load = 1;
        @(negedge wclk);
        af_sel_load = 0;
    endtask

    function automatic int lvl(input int s);
        return ((s + 1) * DEPTH) / 8;
    endfunction

    initial begin
        #(200000 * WCLK_PERIOD);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge rclk);
        wrst_n = 1; rrst_n = 1;
        settle();
        @(negedge wclk);
        // R1 reset state
        check(empty == 1, "R1 empty", empty, 1);
        check(full == 0, "R1 full", full, 0);
        check(almost_full == 0, "R1 almost_full", almost_full, 0);

        // R1 reset select is 7: level DEPTH, almost_full only when full
        for (int n = 1; n <= DEPTH; n++) begin
            wr(8'(n + 8'h40));
            @(negedge wclk);
            check(almost_full == (n >= DEPTH), "R1 R6 default level", almost_full, n >= DEPTH);
            check(full == (n == DEPTH), "R3 full", full, n == DEPTH);
        end
        // R3 writes while full are dropped
        for (int k = 0; k < 3; k++) wr(8'hEE);
        @(negedge wclk);
        check(model_q.size() == DEPTH, "R3 drop count", model_q.size(), DEPTH);
        check(full == 1, "R3 still full", full, 1);
        settle();
        for (int n = 0; n < DEPTH; n++) rd_check("R5 not empty");
        @(negedge rclk);
        check(empty == 1, "R5 empty on last read", empty, 1);

        // R4 read requests while empty are ignored
        @(negedge rclk); rd_ready = 1;
        repeat (3) @(posedge rclk);
        #1 rd_ready = 0;
        wr(8'hA5);
        settle();
        @(negedge rclk);
        check(rd_data == 8'hA5, "R4 head after empty reads", rd_data, 8'hA5);
        rd_check("R5 empty falls");
        @(negedge rclk);
        check(empty == 1, "R4 empty again", empty, 1);
        settle();

        // R6 sweep all preset levels
        for (int s = 0; s < 8; s++) begin
            load_sel(s);
            check(almost_full == 0, "R6 level at zero fill", almost_full, 0);
            for (int n = 1; n <= DEPTH; n++) begin
                wr(8'(s * 16 + n));
                @(negedge wclk);
                check(almost_full == (n >= lvl(s)), "R6 level", almost_full, n >= lvl(s));
            end
            settle();
            for (int n = 0; n < DEPTH; n++) rd_check("R5 drain");
            settle();
            @(negedge wclk);
            check(almost_full == 0, "R6 after drain", almost_full, 0);
        end

        // R2 R7 concurrent traffic, both domains active
        fork
            begin
                int wc = 0;
                while (wc < 60) begin
                    bit acc;
                    @(negedge wclk);
                    if ($urandom_range(0, 2) != 0) begin
                        wr_valid = 1; wr_data = 8'(wc * 3 + 1); acc = !full;
                        @(posedge wclk);
                        if (acc) begin model_q.push_back(wr_data); wc++; end
                        #1 wr_valid = 0;
                    end
                end
            end
            begin
                int rc = 0;
                while (rc < 60) begin
                    @(negedge rclk);
                    if (!empty && $urandom_range(0, 3) != 0) begin
                        check(rd_data == model_q[0], "R2 R7 stream order", rd_data, model_q[0]);
                        rd_ready = 1;
                        @(posedge rclk);
                        #1 rd_ready = 0;
                        void'(model_q.pop_front());
                        rc++;
                    end
                end
            end
        join
        @(negedge rclk);
        check(empty == 1, "R5 empty after stream", empty, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule